// File: doc/BRIEF.md
# Dual Cascadable Timer / Event Counter

The block contains two byte-wide up-counters, A and B. Each has its own compare byte and its own clock-source selector. A counter steps once per tick of its source and starts again at zero when it matches its compare byte. A match also raises a sticky interrupt flag. The tick sources are three taps of a free-running prescaler (divide by 16, 64 and 256) and one external event pin per counter. An event tick is a falling edge of that pin, found by sampling it on the system clock.

A join bit turns the pair into a single 16-bit counter. In that mode B is the high byte and A is the low byte. The 16-bit value is compared against the two compare bytes taken together. The joined counter uses A's clock source and A's run bit. Software programs the block through a plain write port. Nothing flows through the block as a stream, so every pin is a plain control or status pin, with no valid/ready handshake.

Register map, written as address: contents.
- 0, CTRL_A: bits [1:0] source, where 0 is /16, 1 is /64, 2 is /256 and 3 is the event pin. Bit 2 is run. Bit 3 is join.
- 1, CTRL_B: bits [1:0] source and bit 2 run.
- 2, CMP_A.
- 3, CMP_B.
- 4, PIN_EN: bit 0 enables the A event pin and bit 1 enables the B event pin.
- 5, FLAG_CLR: writing a 1 to bit 0 clears irq_a, and writing a 1 to bit 1 clears irq_b.

Top module: `evtimer_pair`

## Requirements
- R1: After reset both counts read 0, both interrupt flags read 0 and both counters are stopped.
- R2: While a counter's run bit is 0, its count is forced to 0 on the next clock and held there. Clearing run on a counter that is running brings its count back to 0.
- R3: With source 0, a running counter steps exactly once every 16 system clocks.
- R4: With source 1 a running counter steps once every 64 clocks, and with source 2 it steps once every 256 clocks.
- R5: On the tick where the count equals the compare byte, the count becomes 0 and the flag sets. The visible sequence is therefore N-1, N, 0, and one period is compare+1 ticks. A compare of 0 keeps the count at 0 and sets the flag on every tick.
- R6: An interrupt flag stays at 1 until software writes 1 to its bit in FLAG_CLR. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R7: With source 3 and the pin enabled, the counter advances once per falling edge of its event pin, and a rising edge does not advance it. A falling edge moves the count within 3 clocks. The event pin must stay at each level for at least 2 clocks.
- R8: When a counter's PIN_EN bit is 0, its event pin is seen as idle, and pulses on it leave the count unchanged.
- R9: With join set, {count_b, count_a} steps as a 16-bit counter on A's source and A's run bit, and CTRL_B is ignored. On a match with {CMP_B, CMP_A}, both bytes clear together, irq_b sets and irq_a stays unchanged.
- R10: Both compare bytes reset to 0xFF, so a counter started without a compare write wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| evt_a | input | 1 | Event pin for counter A |
| evt_b | input | 1 | Event pin for counter B |
| count_a | output | 8 | Count of A (low byte when joined) |
| count_b | output | 8 | Count of B (high byte when joined) |
| irq_a | output | 1 | Sticky match flag of A |
| irq_b | output | 1 | Sticky match flag of B or of the joined pair |

## Verification
A wrong prescaler phase or a wrong tap shows as count steps spaced other than 16, 64 or 256 clocks apart. This is visible at the second step after start. A wrong compare or wrap shows as a step that is not +1 and not N to 0, seen at the first wrap, within compare+1 ticks. A broken carry or a broken joined compare shows as count_b moving at the wrong time, or as irq_a rising in joined mode, no later than the first 16-bit wrap. A wrong event synchronizer shows as a count off by one, seen within 3 clocks of a pin edge.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL_A = 3'd0,
    REG_CTRL_B = 3'd1,
    REG_CMP_A  = 3'd2,
    REG_CMP_B  = 3'd3,
    REG_PIN_EN = 3'd4,
    REG_FLAGCL = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_TAP0 = 2'd0,
    SRC_TAP1 = 2'd1,
    SRC_TAP2 = 2'd2,
    SRC_PIN  = 2'd3
  } src_e;

  localparam int N_TAPS = 3;
endpackage

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int TAP0 = 4,
  parameter int TAP1 = 6,
  parameter int TAP2 = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [2:0] taps
);
  localparam int PW = (TAP2 > TAP1) ? ((TAP2 > TAP0) ? TAP2 : TAP0)
                                    : ((TAP1 > TAP0) ? TAP1 : TAP0);
  localparam int SHIFT [3] = '{TAP0, TAP1, TAP2};

  logic [PW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // A tap ticks once every 2**SHIFT clocks, when its low bits are all ones.
  for (genvar g = 0; g < 3; g++) begin : g_tap
    assign taps[g] = &div_q[SHIFT[g]-1:0];
  end
endmodule

// File: rtl/evt_pin_sync.sv
module evt_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic enable,
  output logic fall
);
  logic s1, s2, s3;
  logic pin_g;

  assign pin_g = enable ? pin : 1'b1;   // a disabled pin reads as idle high

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= pin_g;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign fall = s3 & ~s2;
endmodule

// File: rtl/evt_byte_counter.sv
module evt_byte_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         step,
  input  logic         wrap,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (hold)           cnt <= '0;
    else if (step && wrap)   cnt <= '0;
    else if (step)           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/evtimer_pair.sv
module evtimer_pair
  import evt_pkg::*;
#(
  parameter int W    = 8,
  parameter int TAP0 = 4,
  parameter int TAP1 = 6,
  parameter int TAP2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              evt_a,
  input  logic              evt_b,
  output logic [W-1:0]      count_a,
  output logic [W-1:0]      count_b,
  output logic              irq_a,
  output logic              irq_b
);
  logic [1:0]   src_a, src_b;
  logic         run_a, run_b, join_q;
  logic [W-1:0] cmp_a, cmp_b;
  logic [1:0]   pin_en;
  logic [2:0]   taps;
  logic         fall_a, fall_b;
  logic         tick_a, tick_b;
  logic         eq_a, eq_b, eq_full;
  logic         hold_a, hold_b, step_a, step_b, wrap_a, wrap_b;
  logic         set_a, set_b;
  logic         wsel_flag;

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_a  <= SRC_TAP0;
      src_b  <= SRC_TAP0;
      run_a  <= 1'b0;
      run_b  <= 1'b0;
      join_q <= 1'b0;
      cmp_a  <= '1;
      cmp_b  <= '1;
      pin_en <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_CTRL_A: begin
          src_a  <= wr_data[1:0];
          run_a  <= wr_data[2];
          join_q <= wr_data[3];
        end
        REG_CTRL_B: begin
          src_b <= wr_data[1:0];
          run_b <= wr_data[2];
        end
        REG_CMP_A:  cmp_a  <= wr_data[W-1:0];
        REG_CMP_B:  cmp_b  <= wr_data[W-1:0];
        REG_PIN_EN: pin_en <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  evt_prescaler #(.TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2)) u_pre (
    .clk(clk), .rst_n(rst_n), .taps(taps)
  );

  evt_pin_sync u_sync_a (
    .clk(clk), .rst_n(rst_n), .pin(evt_a), .enable(pin_en[0]), .fall(fall_a)
  );
  evt_pin_sync u_sync_b (
    .clk(clk), .rst_n(rst_n), .pin(evt_b), .enable(pin_en[1]), .fall(fall_b)
  );

  assign tick_a = (src_a == SRC_PIN) ? fall_a : taps[src_a];
  assign tick_b = (src_b == SRC_PIN) ? fall_b : taps[src_b];

  assign eq_a    = (count_a == cmp_a);
  assign eq_b    = (count_b == cmp_b);
  assign eq_full = eq_a & eq_b;

  // lane control: joined pair follows A's source and run bit
  always_comb begin
    hold_a = ~run_a;
    step_a = run_a & tick_a;
    if (join_q) begin
      wrap_a = eq_full;
      hold_b = ~run_a;
      step_b = step_a & (eq_full | (&count_a));
      wrap_b = eq_full;
      set_a  = 1'b0;
      set_b  = step_a & eq_full;
    end else begin
      wrap_a = eq_a;
      hold_b = ~run_b;
      step_b = run_b & tick_b;
      wrap_b = eq_b;
      set_a  = step_a & eq_a;
      set_b  = step_b & eq_b;
    end
  end

  evt_byte_counter #(.W(W)) u_cnt_a (
    .clk(clk), .rst_n(rst_n), .hold(hold_a), .step(step_a), .wrap(wrap_a),
    .cnt(count_a)
  );
  evt_byte_counter #(.W(W)) u_cnt_b (
    .clk(clk), .rst_n(rst_n), .hold(hold_b), .step(step_b), .wrap(wrap_b),
    .cnt(count_b)
  );

  assign wsel_flag = wr_en && (wr_addr == REG_FLAGCL);

  // sticky flags, a set beats a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_a <= 1'b0;
      irq_b <= 1'b0;
    end else begin
      if (set_a)                         irq_a <= 1'b1;
      else if (wsel_flag && wr_data[0])  irq_a <= 1'b0;
      if (set_b)                         irq_b <= 1'b1;
      else if (wsel_flag && wr_data[1])  irq_b <= 1'b0;
    end
  end
endmodule

// File: rtl/evtimer_pair_chk.sv
module evtimer_pair_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   wr_addr,
  input logic [7:0]   wr_data,
  input logic         run_a,
  input logic         run_b,
  input logic         join_q,
  input logic         tick_a,
  input logic [W-1:0] cmp_a,
  input logic [W-1:0] count_a,
  input logic [W-1:0] count_b,
  input logic         irq_a
);
  a_r2_hold_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    !run_a |=> (count_a == '0));

  a_r2_hold_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!join_q && !run_b) |=> (count_b == '0));

  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!join_q && run_a && !tick_a) |=> $stable(count_a));

  a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!join_q && run_a && tick_a && count_a == cmp_a) |=> (count_a == '0 && irq_a));

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a && !(wr_en && wr_addr == 3'd5 && wr_data[0])) |=> irq_a);

  a_r9_joined_no_irq_a: assert property (@(posedge clk) disable iff (!rst_n)
    join_q |=> !$rose(irq_a));
endmodule

bind evtimer_pair evtimer_pair_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .run_a(run_a), .run_b(run_b), .join_q(join_q), .tick_a(tick_a),
  .cmp_a(cmp_a), .count_a(count_a), .count_b(count_b), .irq_a(irq_a)
);

// File: tb/test_evtimer_pair.sv
module test_evtimer_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       evt_a = 1'b1;
  logic       evt_b = 1'b1;
  logic [7:0] count_a, count_b;
  logic       irq_a, irq_b;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  evtimer_pair i_evtimer_pair (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .evt_a(evt_a), .evt_b(evt_b), .count_a(count_a), .count_b(count_b),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // sel 0: A, 1: B, 2: joined {B,A}. Checks every step against +1 / wrap,
  // the spacing of steps, and the flag at each wrap.
  task automatic watch(input int sel, input int cmp, input int period,
                       input int cycles, input string req);
    int prev, cur, last, bad, wraps, expv;
    bit fl, other;
    prev = 0; last = -1; bad = 0; wraps = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      cur   = (sel == 0) ? int'(count_a) : (sel == 1) ? int'(count_b)
                                         : int'({count_b, count_a});
      fl    = (sel == 0) ? irq_a : irq_b;
      other = (sel == 2) ? irq_a : 1'b0;
      if (other) bad++;
      if (cur != prev) begin
        expv = (prev == cmp) ? 0 : prev + 1;
        if (cur != expv) bad++;
        if (last >= 0 && (i - last) != period) bad++;
        if (expv == 0) begin
          wraps++;
          if (!fl) bad++;
        end else if (wraps == 0 && fl) bad++;
        last = i;
        prev = cur;
      end
    end
    chk(bad == 0 && wraps > 0, req, bad, 0);
  endtask

  task automatic pulse_b(input bit en_expect, input int base, output int bad);
    bad = 0;
    @(negedge clk); evt_b = 1'b0;
    repeat (4) @(negedge clk);
    if (en_expect && count_b == base[7:0]) bad++;
    if (!en_expect && count_b != base[7:0]) bad++;
    evt_b = 1'b1;
    begin
      logic [7:0] after_fall;
      after_fall = count_b;
      repeat (4) @(negedge clk);
      if (count_b != after_fall) bad++;   // rising edge must not step (R7)
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(count_a == 0, "R1 count_a", count_a, 0);
    chk(count_b == 0, "R1 count_b", count_b, 0);
    chk(irq_a == 0 && irq_b == 0, "R1 flags", {irq_b, irq_a}, 0);
    repeat (300) @(negedge clk);
    chk(count_a == 0 && count_b == 0, "R1 stopped", count_a, 0);

    // R10 reset compare of 0xFF on A, /16
    wr(3'd0, 8'h04);
    watch(0, 255, 16, 256 * 16 + 40, "R10 default compare wrap");

    // R2 stop clears a running count
    repeat (40) @(negedge clk);
    wr(3'd0, 8'h00);
    @(negedge clk);
    chk(count_a == 0, "R2 stop clears", count_a, 0);
    repeat (100) @(negedge clk);
    chk(count_a == 0, "R2 stays zero", count_a, 0);

    // R6 flag sticky until written clear
    chk(irq_a == 1, "R6 flag held", irq_a, 1);
    wr(3'd5, 8'h01);
    chk(irq_a == 0, "R6 flag cleared", irq_a, 0);

    // R3 and R5 sweep of compare values at /16
    for (int c = 1; c <= 6; c++) begin
      wr(3'd0, 8'h00);
      wr(3'd2, c[7:0]);
      wr(3'd5, 8'h03);
      wr(3'd0, 8'h04);
      watch(0, c, 16, (c + 1) * 16 * 3, "R3 R5 /16 sweep");
    end

    // R5 compare of zero
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd5, 8'h03);
    wr(3'd0, 8'h04);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (count_a != 0) bad++;
    end
    chk(bad == 0 && irq_a == 1, "R5 compare zero", bad, 0);

    // R4 slower taps
    wr(3'd0, 8'h00);
    wr(3'd2, 8'd2);
    wr(3'd5, 8'h03);
    wr(3'd0, 8'h05);
    watch(0, 2, 64, 3 * 64 * 3, "R4 /64");
    wr(3'd0, 8'h00);
    wr(3'd2, 8'd1);
    wr(3'd5, 8'h03);
    wr(3'd0, 8'h06);
    watch(0, 1, 256, 2 * 256 * 3, "R4 /256");
    wr(3'd0, 8'h00);

    // counter B on its own, /16
    wr(3'd3, 8'd3);
    wr(3'd5, 8'h03);
    wr(3'd1, 8'h04);
    watch(1, 3, 16, 4 * 16 * 3, "R3 R5 lane B");
    wr(3'd1, 8'h00);

    // R9 joined pair, CTRL_B stopped but ignored
    wr(3'd2, 8'h03);
    wr(3'd3, 8'h01);
    wr(3'd5, 8'h03);
    wr(3'd0, 8'h0C);
    watch(2, 16'h0103, 16, 260 * 16 + 40, "R9 joined 16-bit");
    chk(irq_a == 0, "R9 irq_a untouched", irq_a, 0);
    wr(3'd0, 8'h00);

    // R8 event pin disabled
    wr(3'd3, 8'd2);
    wr(3'd5, 8'h03);
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h07);
    for (int p = 0; p < 3; p++) begin
      pulse_b(1'b0, 0, bad);
      chk(bad == 0, "R8 disabled pin ignored", count_b, 0);
    end

    // R7 event pin enabled, falling edges only
    wr(3'd4, 8'h02);
    for (int p = 0; p < 7; p++) begin
      pulse_b(1'b1, p % 3, bad);
      chk(bad == 0 && count_b == 8'((p + 1) % 3), "R7 falling edge step",
          count_b, (p + 1) % 3);
    end
    chk(irq_b == 1, "R7 R5 event wrap flag", irq_b, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule